// File: doc/BRIEF.md
# Subtract-and-Swap Greatest Common Divisor Unit

The unit takes two unsigned 8-bit operands and works out their greatest common divisor. It uses Euclid's method in its subtraction form. Each pass of the loop compares the two working values. If they are equal the unit stops. If the first is smaller it skips the swap. If the first is larger it swaps them first. It then checks whether the smaller value has reached one, and if not it subtracts the smaller value from the larger and goes round again. A zero operand is caught at launch, so the loop never runs with a zero value.

A client uses a level handshake. It places the operands on the inputs and raises `start`. It waits for `ready`, reads `gcd_out`, and then lowers `start`. The unit copies the operands into its working registers on every cycle while it is idle. Only the values present on the edge where `start` is first seen are used. While `start` stays high, `ready` and the result do not change. Dropping `start` returns the unit to idle.

The controller has eight states, each named below:

- `ST_IDLE`: loads the operands and waits for start.
- `ST_COMPARE`: registers the equal and less-than flags.
- `ST_BRANCH`: moves to `ST_DONE` on equal, to `ST_CHECK_ONE` on less-than, and to `ST_SWAP` otherwise.
- `ST_SWAP`: exchanges the two working values and moves to `ST_CHECK_ONE`.
- `ST_CHECK_ONE`: registers the is-one flag.
- `ST_TEST_ONE`: moves to `ST_DONE` if the flag is set, otherwise to `ST_SUBTRACT`.
- `ST_SUBTRACT`: replaces the larger value with the difference and moves to `ST_COMPARE`.
- `ST_DONE`: asserts `ready` and holds there until `start` is low.

A launch with a zero operand goes from `ST_IDLE` straight to `ST_DONE`.

Top module: `euclid_gcd_unit`

## Requirements
- R1: While `rst` is high on a rising edge, the unit returns to idle. After that edge, `ready` is 0 and `gcd_out` is 0.
- R2: While idle, `ready` is 0. Operand values present before the launch edge (the edge where `start` is first sampled high) have no effect on the result.
- R3: For two nonzero operands, the result shown when `ready` rises equals their greatest common divisor. For example, (9,15)→3, (15,9)→3, (15,14)→1, (18,36)→18, (91,39)→13 and (127,127)→127.
- R4: If either operand is zero at the launch edge, `ready` is high one cycle after launch. The result is the other operand, or 0 when both are zero.
- R5: For equal nonzero operands, the path is compare, branch, done. `ready` is first high 3 cycles after launch, and the result is the operand value.
- R6: When the first operand is smaller, the swap is skipped. With first operand 1 and second operand larger, `ready` is first high 5 cycles after launch, with result 1.
- R7: When the first operand is larger, the values are swapped before the one-check. With second operand 1 and first operand larger, `ready` is first high 6 cycles after launch, with result 1.
- R8: Changes on `opnd_a` and `opnd_b` after the launch edge have no effect on the result.
- R9: While in done with `start` high, `ready` stays 1 and `gcd_out` holds the result, whatever the operand inputs do.
- R10: When `start` is sampled low in done, `ready` is 0 one cycle later and the unit is idle. The next raise of `start` launches a fresh computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Level request; launches from idle, releases done |
| opnd_a | input | 8 | First operand, captured while idle |
| opnd_b | input | 8 | Second operand, captured while idle |
| gcd_out | output | 8 | Result; valid while `ready` is high |
| ready | output | 1 | High only in the done state |

## Verification
Inputs change on falling edges, and outputs are sampled on falling edges. Latency is therefore counted as whole cycles from the launch edge.

The fixed-path cases have exact due times:

| Case | `ready` first high |
|------|--------------------|
| zero operand | 1 cycle after launch |
| equal operands | 3 cycles after launch |
| smaller first operand of 1 | 5 cycles after launch |
| swapped path with second operand 1 | 6 cycles after launch |

For each of these, the bench checks that `ready` is first observed high on exactly that falling edge. Random pairs have latencies that depend on the data, so the bench waits for `ready` and compares the result with a modulo-based reference. It then holds `start` for three more cycles, changing the operands, and checks that the outputs do not move. Finally it lowers `start` and expects `ready` low on the very next falling edge.

// File: rtl/euclid_gcd_pkg.sv
package euclid_gcd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_BRANCH,
        ST_SWAP,
        ST_CHECK_ONE,
        ST_TEST_ONE,
        ST_SUBTRACT,
        ST_DONE
    } gcd_state_e;

    // One enable per datapath action; at most one is active in any cycle.
    typedef struct packed {
        logic load;
        logic cmp;
        logic swap;
        logic chk;
        logic sub;
    } gcd_ctl_t;

endpackage

// File: rtl/euclid_gcd_cmp.sv
module euclid_gcd_cmp #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] work_a,
    input  logic [WIDTH-1:0] work_b,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             eq_c,
    output logic             lt_c,
    output logic             one_c,
    output logic             zero_any
);

    localparam logic [WIDTH-1:0] ONE_VAL = WIDTH'(1);

    always_comb begin
        eq_c     = (work_a == work_b);
        lt_c     = (work_a <  work_b);
        one_c    = (work_a == ONE_VAL);
        zero_any = (opnd_a == '0) || (opnd_b == '0);
    end

endmodule

// File: rtl/euclid_gcd_ctrl.sv
module euclid_gcd_ctrl
    import euclid_gcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     zero_any,
    input  logic     eq_flag,
    input  logic     lt_flag,
    input  logic     one_flag,
    output gcd_ctl_t ctl,
    output logic     ready
);

    gcd_state_e state_q;
    gcd_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = zero_any ? ST_DONE : ST_COMPARE;
                end
            end
            ST_COMPARE:   state_d = ST_BRANCH;
            ST_BRANCH: begin
                if (eq_flag) begin
                    state_d = ST_DONE;
                end else if (lt_flag) begin
                    state_d = ST_CHECK_ONE;
                end else begin
                    state_d = ST_SWAP;
                end
            end
            ST_SWAP:      state_d = ST_CHECK_ONE;
            ST_CHECK_ONE: state_d = ST_TEST_ONE;
            ST_TEST_ONE:  state_d = one_flag ? ST_DONE : ST_SUBTRACT;
            ST_SUBTRACT:  state_d = ST_COMPARE;
            ST_DONE: begin
                if (!start) begin
                    state_d = ST_IDLE;
                end
            end
            default:      state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        ctl   = '0;
        ready = 1'b0;
        unique case (state_q)
            ST_IDLE:      ctl.load = 1'b1;
            ST_COMPARE:   ctl.cmp  = 1'b1;
            ST_BRANCH:    ;
            ST_SWAP:      ctl.swap = 1'b1;
            ST_CHECK_ONE: ctl.chk  = 1'b1;
            ST_TEST_ONE:  ;
            ST_SUBTRACT:  ctl.sub  = 1'b1;
            ST_DONE:      ready    = 1'b1;
            default:      ;
        endcase
    end

    // R2: a launch with nonzero operands enters the compare step
    a_r2_launch_compare: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && !zero_any) |=> (state_q == ST_COMPARE));

    // R4: a launch with a zero operand finishes on the next edge
    a_r4_zero_shortcut: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start && zero_any) |=> ready);

    // R9: ready stays high while start is held
    a_r9_ready_held: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> ready);

    // R10: releasing start in done returns to idle
    a_r10_release_idle: assert property (@(posedge clk) disable iff (rst)
        (ready && !start) |=> (!ready && state_q == ST_IDLE));

endmodule

// File: rtl/euclid_gcd_datapath.sv
module euclid_gcd_datapath
    import euclid_gcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  gcd_ctl_t         ctl,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             eq_c,
    input  logic             lt_c,
    input  logic             one_c,
    output logic [WIDTH-1:0] work_a,
    output logic [WIDTH-1:0] work_b,
    output logic             eq_flag,
    output logic             lt_flag,
    output logic             one_flag
);

    logic [WIDTH-1:0] load_a;
    logic [WIDTH-1:0] diff;

    // A zero first operand is replaced by the second, so done shows the other operand.
    always_comb begin
        load_a = (opnd_a == '0) ? opnd_b : opnd_a;
        diff   = work_b - work_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work_a   <= '0;
            work_b   <= '0;
            eq_flag  <= 1'b0;
            lt_flag  <= 1'b0;
            one_flag <= 1'b0;
        end else begin
            if (ctl.load) begin
                work_a <= load_a;
                work_b <= opnd_b;
            end
            if (ctl.cmp) begin
                eq_flag <= eq_c;
                lt_flag <= lt_c;
            end
            if (ctl.swap) begin
                work_a <= work_b;
                work_b <= work_a;
            end
            if (ctl.chk) begin
                one_flag <= one_c;
            end
            if (ctl.sub) begin
                work_b <= diff;
            end
        end
    end

    // R3: only one datapath action per cycle
    a_r3_single_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.load, ctl.cmp, ctl.swap, ctl.chk, ctl.sub}));

    // R3: equal and less-than never both set
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(eq_flag && lt_flag));

    // R3: subtraction only runs on a strictly larger minuend
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (rst)
        ctl.sub |-> (work_b > work_a));

    // R7: swap exchanges the working values
    a_r7_swap_exchange: assert property (@(posedge clk) disable iff (rst)
        ctl.swap |=> (work_a == $past(work_b) && work_b == $past(work_a)));

endmodule

// File: rtl/euclid_gcd_unit.sv
module euclid_gcd_unit
    import euclid_gcd_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] gcd_out,
    output logic             ready
);

    gcd_ctl_t         ctl;
    logic [WIDTH-1:0] work_a;
    logic [WIDTH-1:0] work_b;
    logic             eq_c;
    logic             lt_c;
    logic             one_c;
    logic             zero_any;
    logic             eq_flag;
    logic             lt_flag;
    logic             one_flag;

    euclid_gcd_cmp #(.WIDTH(WIDTH)) u_cmp (
        .work_a   (work_a),
        .work_b   (work_b),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .eq_c     (eq_c),
        .lt_c     (lt_c),
        .one_c    (one_c),
        .zero_any (zero_any)
    );

    euclid_gcd_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .zero_any (zero_any),
        .eq_flag  (eq_flag),
        .lt_flag  (lt_flag),
        .one_flag (one_flag),
        .ctl      (ctl),
        .ready    (ready)
    );

    euclid_gcd_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .eq_c     (eq_c),
        .lt_c     (lt_c),
        .one_c    (one_c),
        .work_a   (work_a),
        .work_b   (work_b),
        .eq_flag  (eq_flag),
        .lt_flag  (lt_flag),
        .one_flag (one_flag)
    );

    assign gcd_out = work_a;

    // R9: result frozen while done is held by start
    a_r9_result_stable: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> $stable(gcd_out));

endmodule

// File: tb/euclid_gcd_unit_test.sv
`timescale 1ns/1ps
module euclid_gcd_unit_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] opnd_a;
    logic [7:0] opnd_b;
    logic [7:0] gcd_out;
    logic       ready;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    euclid_gcd_unit uut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .gcd_out (gcd_out),
        .ready   (ready)
    );

    function automatic int gcd_ref(input int a, input int b);
        int x = a;
        int y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // exp_lat > 0 demands ready first high exactly that many cycles after launch
    task automatic run_op(input logic [7:0] a, input logic [7:0] b,
                          input int exp_lat, input string tag);
        int cyc = 0;
        int exp = gcd_ref(a, b);
        @(negedge clk);
        opnd_a = a;
        opnd_b = b;
        start  = 1'b1;
        do begin
            @(negedge clk);
            cyc++;
            if (!ready) begin
                // R8: disturb operands after launch
                opnd_a = a ^ 8'h5A;
                opnd_b = b + 8'd7;
            end
        end while (!ready && cyc <= 4000);
        if (!ready) begin
            check(1'b0, {tag, " timeout"}, cyc, 4000);
            start = 1'b0;
            return;
        end
        check(gcd_out == 8'(exp), {tag, " R8 result"}, gcd_out, exp);
        if (exp_lat > 0) begin
            check(cyc == exp_lat, {tag, " latency"}, cyc, exp_lat);
        end
        for (int k = 0; k < 3; k++) begin
            opnd_a = 8'($urandom);
            opnd_b = 8'($urandom);
            @(negedge clk);
            check(ready == 1'b1, "R9 ready held", ready, 1);
            check(gcd_out == 8'(exp), "R9 result held", gcd_out, exp);
        end
        start = 1'b0;
        @(negedge clk);
        check(ready == 1'b0, "R10 ready release", ready, 0);
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        rst    = 1'b1;
        start  = 1'b0;
        opnd_a = 8'd0;
        opnd_b = 8'd0;
        repeat (3) @(negedge clk);
        check(ready == 1'b0, "R1 ready after reset", ready, 0);
        check(gcd_out == 8'd0, "R1 result after reset", gcd_out, 0);
        rst = 1'b0;

        // R2: junk operands while idle, then launch with real ones
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(ready == 1'b0, "R2 idle ready low", ready, 0);
            opnd_a = 8'($urandom);
            opnd_b = 8'($urandom);
        end
        run_op(8'd9,   8'd15,  0, "R2");

        run_op(8'd15,  8'd9,   0, "R3");
        run_op(8'd15,  8'd14,  0, "R3");
        run_op(8'd18,  8'd36,  0, "R3");
        run_op(8'd91,  8'd39,  0, "R3");
        run_op(8'd127, 8'd127, 0, "R3");

        run_op(8'd0,   8'd12,  1, "R4");
        run_op(8'd12,  8'd0,   1, "R4");
        run_op(8'd0,   8'd0,   1, "R4");

        run_op(8'd77,  8'd77,  3, "R5");
        run_op(8'd1,   8'd5,   5, "R6");
        run_op(8'd5,   8'd1,   6, "R7");
        run_op(8'd2,   8'd255, 0, "R6");
        run_op(8'd255, 8'd2,   0, "R7");

        for (int i = 0; i < 60; i++) begin
            logic [7:0] ra;
            logic [7:0] rb;
            ra = 8'($urandom_range(1, 255));
            rb = 8'($urandom_range(1, 255));
            run_op(ra, rb, 0, "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule